// File: doc/BRIEF.md
# Supply Lockout Write Permission Timer

This block decides whether a nonvolatile memory may begin an internal write cycle. It watches a single comparator flag that is high while the supply is at or above the lockout threshold. The flag is brought into the clock domain through a two-flop synchroniser and then debounced: a new level must persist for a programmable number of clocks before the block believes it. Short spikes in either direction are therefore discarded.

Permission is asymmetric in time. When the filtered flag falls, write permission is withdrawn within a few clocks. When the filtered flag rises, permission returns only after the supply has stayed good for a long power-up delay (nominally around 200 ms, counted in clocks). Any qualified dip during that delay clears the count, so the full delay starts again. Read requests are never affected. Write requests only produce a write start while permission is held, and a write that has already started is never cut short by this block.

Top module: `supply_wr_gate`

## Requirements
- R1: After a synchronous reset, `wr_en` is 0 and `wr_start` is 0 even with `wr_req` held at 1.
- R2: A level change on `supply_ok` lasting fewer than `FLT_CYC` clock edges has no effect on `wr_en`, whether it is a low spike while permission is held or a high spike while locked.
- R3: When `supply_ok` falls and stays low, `wr_en` goes to 0 exactly `FLT_CYC + 3` rising edges after the change (2 synchroniser stages, `FLT_CYC` filter edges, 1 timer edge).
- R4: When `supply_ok` rises and stays high from a settled low state, `wr_en` remains 0 for `FLT_CYC + PUW_CYC + 1` edges and becomes 1 on edge `FLT_CYC + PUW_CYC + 2`, then stays 1.
- R5: A qualified low (at least `FLT_CYC` edges) during the power-up delay clears the delay count; `wr_en` then rises exactly `FLT_CYC + PUW_CYC + 2` edges after the final rise of `supply_ok`.
- R6: `wr_start` equals `wr_req` while `wr_en` is 1 and is 0 while `wr_en` is 0.
- R7: `rd_start` always equals `rd_req`, with or without write permission.
- R8: `wr_en` is 0 on the edge after the filtered supply flag is seen low, and it rises only while that flag is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Asynchronous comparator flag, 1 = supply at or above threshold |
| wr_req | input | 1 | Request to start an internal write cycle |
| rd_req | input | 1 | Request to start a read |
| wr_en | output | 1 | Write permission |
| wr_start | output | 1 | Write start, request gated by permission |
| rd_start | output | 1 | Read start, never gated |

## Verification
The bench builds the block with `FLT_CYC = 4` and `PUW_CYC = 40`, in place of the production values sized for tens of millions of clocks. The short delay brings the exact edge of permission return within reach, together with a dip in the middle of the count and the restart that follows it. The four-clock filter lets spikes of three clocks be shown to vanish while a five-clock dip is shown to qualify.

// File: rtl/supply_lock_pkg.sv
package supply_lock_pkg;

    typedef enum logic [1:0] {
        LK_LOCKED = 2'd0,
        LK_ARMING = 2'd1,
        LK_OPEN   = 2'd2
    } lock_state_e;

    // Bits needed for a counter that must hold values 0 .. n-1.
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/flag_sync2.sv
module flag_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic stage1;
    logic stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= 1'b0;
            stage2 <= 1'b0;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;

    // R2
    sync_chain_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (stage2 == $past(stage1)));
endmodule

// File: rtl/level_debounce.sv
module level_debounce
    import supply_lock_pkg::*;
#(
    parameter int unsigned FLT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_in,
    output logic lvl_out
);
    localparam int unsigned FW = cnt_bits(FLT_CYC);
    localparam logic [FW-1:0] LAST = FW'(FLT_CYC - 1);

    logic          held;
    logic [FW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= 1'b0;
            run  <= '0;
        end else if (lvl_in == held) begin
            run <= '0;
        end else if (run == LAST) begin
            held <= lvl_in;
            run  <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

    assign lvl_out = held;

    // R2: the output only ever moves toward a level the input presented
    flt_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (held != $past(held)) |-> ($past(lvl_in) == held));
endmodule

// File: rtl/powerup_delay.sv
module powerup_delay
    import supply_lock_pkg::*;
#(
    parameter int unsigned PUW_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic good,
    output logic permit
);
    localparam int unsigned CW = cnt_bits(PUW_CYC);
    localparam logic [CW-1:0] DONE = CW'(PUW_CYC - 1);

    lock_state_e   state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LK_LOCKED;
            cnt   <= '0;
        end else if (!good) begin
            state <= LK_LOCKED;
            cnt   <= '0;
        end else begin
            unique case (state)
                LK_LOCKED: begin
                    state <= LK_ARMING;
                    cnt   <= CW'(1);
                end
                LK_ARMING: begin
                    if (cnt == DONE) begin
                        state <= LK_OPEN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= LK_OPEN;
            endcase
        end
    end

    assign permit = (state == LK_OPEN);

    initial begin
        puw_min_chk: assert (PUW_CYC >= 2);
    end

    // R8
    drop_chk: assert property (@(posedge clk) disable iff (rst)
        !good |=> !permit);

    // R8
    rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(permit) |-> $past(good));
endmodule

// File: rtl/supply_wr_gate.sv
module supply_wr_gate
    import supply_lock_pkg::*;
#(
    parameter int unsigned FLT_CYC = 6,
    parameter int unsigned PUW_CYC = 40_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic wr_req,
    input  logic rd_req,
    output logic wr_en,
    output logic wr_start,
    output logic rd_start
);
    logic ok_sync;
    logic ok_filt;

    flag_sync2 u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (supply_ok),
        .q_sync  (ok_sync)
    );

    level_debounce #(.FLT_CYC(FLT_CYC)) u_filt (
        .clk     (clk),
        .rst     (rst),
        .lvl_in  (ok_sync),
        .lvl_out (ok_filt)
    );

    powerup_delay #(.PUW_CYC(PUW_CYC)) u_delay (
        .clk    (clk),
        .rst    (rst),
        .good   (ok_filt),
        .permit (wr_en)
    );

    assign wr_start = wr_req & wr_en;
    assign rd_start = rd_req;

    // R1
    reset_lock_chk: assert property (@(posedge clk)
        $past(rst) |-> !wr_en);

    // R6
    gate_chk: assert property (@(posedge clk) disable iff (rst)
        wr_start |-> wr_en);

    // R7
    read_pass_chk: assert property (@(posedge clk) disable iff (rst)
        rd_start == rd_req);
endmodule

// File: tb/supply_wr_gate_tb.sv
module supply_wr_gate_tb;
    localparam int unsigned FLT  = 4;
    localparam int unsigned PUW  = 40;
    localparam int unsigned L_UP = FLT + PUW + 2;
    localparam int unsigned L_DN = FLT + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b0;
    logic wr_req = 1'b0;
    logic rd_req = 1'b0;
    logic wr_en, wr_start, rd_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    supply_wr_gate #(.FLT_CYC(FLT), .PUW_CYC(PUW)) u_dut (
        .clk (clk), .rst (rst), .supply_ok (supply_ok),
        .wr_req (wr_req), .rd_req (rd_req),
        .wr_en (wr_en), .wr_start (wr_start), .rd_start (rd_start)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int unsigned n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Hold wr_en at the expected level for n edges; one check for the window.
    task automatic hold_window(input string req, input int unsigned n, input logic exp);
        logic bad = 1'b0;
        logic seen = exp;
        for (int i = 0; i < int'(n); i++) begin
            edges(1);
            if (wr_en !== exp) begin
                bad = 1'b1;
                seen = wr_en;
            end
        end
        chk(req, bad ? seen : exp, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; supply_ok = 1'b0; wr_req = 1'b1;
        edges(3);
        chk("R1 wr_en after reset", wr_en, 1'b0);
        chk("R1 wr_start after reset", wr_start, 1'b0);
        @(negedge clk);
        rst = 1'b0; wr_req = 1'b0;
    endtask

    task automatic t_powerup();
        @(negedge clk);
        supply_ok = 1'b1;
        edges(L_UP - 1);
        chk("R4 wr_en before delay end", wr_en, 1'b0);
        edges(1);
        chk("R4 wr_en at delay end", wr_en, 1'b1);
        hold_window("R4 wr_en stays high", 10, 1'b1);
    endtask

    task automatic t_glitch_low();
        @(negedge clk);
        supply_ok = 1'b0;
        repeat (FLT - 1) @(negedge clk);
        supply_ok = 1'b1;
        hold_window("R2 short low spike ignored", 2 * FLT + 6, 1'b1);
    endtask

    task automatic t_fall();
        @(negedge clk);
        supply_ok = 1'b0;
        edges(L_DN - 1);
        chk("R3 wr_en before lockout edge", wr_en, 1'b1);
        edges(1);
        chk("R3 wr_en at lockout edge", wr_en, 1'b0);
        hold_window("R8 wr_en held low", FLT + 4, 1'b0);
    endtask

    task automatic t_glitch_high();
        @(negedge clk);
        supply_ok = 1'b1;
        repeat (FLT - 1) @(negedge clk);
        supply_ok = 1'b0;
        hold_window("R2 short high spike ignored", L_UP + 4, 1'b0);
        t_powerup();
    endtask

    task automatic t_restart();
        @(negedge clk);
        supply_ok = 1'b0;
        edges(L_DN + FLT + 4);
        @(negedge clk);
        supply_ok = 1'b1;
        repeat (PUW / 2) @(negedge clk);
        supply_ok = 1'b0;
        repeat (FLT + 1) @(negedge clk);
        chk("R5 wr_en low during dip", wr_en, 1'b0);
        supply_ok = 1'b1;
        edges(L_UP - 1);
        chk("R5 delay restarted, still low", wr_en, 1'b0);
        edges(1);
        chk("R5 wr_en after full restarted delay", wr_en, 1'b1);
    endtask

    task automatic t_gating();
        @(negedge clk);
        wr_req = 1'b1; rd_req = 1'b1;
        #1;
        chk("R6 wr_start while permitted", wr_start, 1'b1);
        chk("R7 rd_start while permitted", rd_start, 1'b1);
        supply_ok = 1'b0;
        edges(L_DN);
        chk("R6 wr_start blocked when locked", wr_start, 1'b0);
        chk("R7 rd_start while locked", rd_start, 1'b1);
        @(negedge clk);
        rd_req = 1'b0;
        #1;
        chk("R7 rd_start follows low request", rd_start, 1'b0);
        wr_req = 1'b0;
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_glitch_low();
        t_fall();
        t_glitch_high();
        t_restart();
        t_gating();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule